// File: doc/BRIEF.md
# Serial Receive Path with Per-Character Error Tracking

This block is the receive half of an asynchronous serial port. A 2-flop synchroniser brings the serial line into the clock domain. The block then samples the line on a 16x baud enable and checks each start bit at its midpoint. It assembles characters of 5 to 8 data bits, least significant bit first, with optional even or odd parity. The word-length, parity and stop settings come from the same configuration that drives the transmitter.

Each finished character goes into a 64-entry receive queue. Three error flags travel with it in the queue: parity error, framing error and break. The head of the queue is visible on the read-data port together with its own flags, and a one-cycle pop strobe consumes it. The block also reports:
- data-ready;
- a sticky overrun flag;
- a summary bit that is set while any queued character carries an error;
- a trigger output that compares the fill level with one of four programmable thresholds.

Register decoding and interrupt ranking stay in the surrounding logic, which reads these status outputs.

Top module: `uart_rx_core`

## Requirements
- R1: After reset the queue is empty, the fill level is 0, and data-ready, overrun, head flags, error summary and trigger are all low.
- R2: A low level on the line counts as a start bit only if the line is still low 8 baud ticks after it was first seen. A shorter low pulse loads nothing.
- R3: Data bits are sampled at their centres and taken LSB first. The word-length code 00/01/10/11 selects 5/6/7/8 bits, and the unused upper bits of the read data are 0.
- R4: When parity is enabled, a parity bit follows the data. The parity error flag of that character is set when the bit differs from the configured sense: even means the data plus parity hold an even count of ones, odd means an odd count. With parity disabled the flag is never set.
- R5: A character whose first stop bit is sampled low, and which is not a break, carries the framing error flag. Only the first stop bit is checked. The receiver then returns to hunting for a start bit and receives the following characters correctly.
- R6: When the line stays low through start, data, parity and first stop bit, exactly one character of value 0 with the break flag set (parity and framing flags clear) is loaded. Nothing more is loaded until the line has gone high again.
- R7: The queue is first-in first-out with 64 entries. Data-ready is high exactly when the fill level is non-zero. A pop while the queue is empty has no effect.
- R8: A character that completes while the queue holds 64 entries sets the overrun flag and is discarded, and the queue contents and level stay unchanged. The overrun flag stays set until the acknowledge input is pulsed.
- R9: A clear pulse empties the queue and drops the error summary. It does not change the overrun flag.
- R10: The trigger output is high when the fill level is at least 1, 16, 32 or 56 for trigger code 00, 01, 10 or 11.
- R11: The error summary is high while at least one queued character carries a parity, framing or break flag.
- R12: The parity, framing and break outputs show the flags of the character at the head of the queue, and are low while the queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | 16x baud-rate enable |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| cfg_wlen | input | 2 | Word-length code: 00=5, 01=6, 10=7, 11=8 bits |
| cfg_two_stop | input | 1 | Two stop bits (only the first is checked) |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_even | input | 1 | 1 = even parity, 0 = odd parity |
| cfg_trig | input | 2 | Trigger threshold code |
| q_clear | input | 1 | Empty the receive queue |
| q_pop | input | 1 | Consume the head character |
| ovr_ack | input | 1 | Clear the overrun flag |
| rd_data | output | 8 | Head character data |
| st_ready | output | 1 | Queue not empty |
| st_overrun | output | 1 | Sticky overrun flag |
| st_parity | output | 1 | Head character parity error |
| st_framing | output | 1 | Head character framing error |
| st_break | output | 1 | Head character is a break |
| st_q_err | output | 1 | Some queued character has an error |
| trig_hit | output | 1 | Fill level at or above threshold |
| fill_level | output | 7 | Number of queued characters |

## Verification
A corrupted queue pointer or entry shows up at the next pop: the read data or head flags differ from the expected character, and the fill level differs at once. A wrong sampling counter shifts every later bit, so the first character after the fault has wrong data or a spurious framing error. A wrong error counter shows in the summary bit as soon as the last erroneous character is popped or the queue is cleared. A state machine stuck after a break shows as a missing character on the next frame.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    typedef struct packed {
        logic       brk;
        logic       frm;
        logic       par;
        logic [7:0] data;
    } rx_char_t;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP,
        RX_HOLD
    } rx_state_t;

    function automatic logic [3:0] word_bits(input logic [1:0] code);
        return 4'd5 + {2'b00, code};
    endfunction

    function automatic int unsigned trig_level(input logic [1:0] code);
        case (code)
            2'b00:   return 1;
            2'b01:   return 16;
            2'b10:   return 32;
            default: return 56;
        endcase
    endfunction

    function automatic logic has_err(input rx_char_t c);
        return c.brk | c.frm | c.par;
    endfunction

endpackage

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
    import uart_rx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     baud_tick,
    input  logic     rx_line,
    input  logic [1:0] cfg_wlen,
    input  logic     cfg_par_en,
    input  logic     cfg_par_even,
    output logic     char_valid,
    output rx_char_t char_out
);
    localparam int CW  = $clog2(OSR);
    localparam int MID = OSR / 2 - 1;

    logic      sync_a, sync_b;
    rx_state_t state;
    logic [CW-1:0] cnt;
    logic [2:0]    bitn;
    logic [7:0]    shreg;
    logic          ones_par;
    logic          all_low;
    logic          par_bit;
    logic [3:0]    nbits;
    logic          centre;

    assign nbits  = word_bits(cfg_wlen);
    assign centre = (cnt == CW'(OSR - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_a <= 1'b1;
            sync_b <= 1'b1;
        end else begin
            sync_a <= rx_line;
            sync_b <= sync_a;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= RX_IDLE;
            cnt        <= '0;
            bitn       <= '0;
            shreg      <= '0;
            ones_par   <= 1'b0;
            all_low    <= 1'b1;
            par_bit    <= 1'b0;
            char_valid <= 1'b0;
            char_out   <= '0;
        end else begin
            char_valid <= 1'b0;
            if (baud_tick) begin
                case (state)
                    RX_IDLE: begin
                        if (!sync_b) begin
                            state <= RX_START;
                            cnt   <= '0;
                        end
                    end
                    RX_START: begin
                        if (cnt == CW'(MID)) begin
                            cnt <= '0;
                            if (sync_b) begin
                                state <= RX_IDLE;
                            end else begin
                                state    <= RX_DATA;
                                bitn     <= '0;
                                shreg    <= '0;
                                ones_par <= 1'b0;
                                all_low  <= 1'b1;
                                par_bit  <= 1'b0;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    RX_DATA: begin
                        cnt <= cnt + 1'b1;
                        if (centre) begin
                            cnt      <= '0;
                            shreg    <= {sync_b, shreg[7:1]};
                            ones_par <= ones_par ^ sync_b;
                            all_low  <= all_low & ~sync_b;
                            if ({1'b0, bitn} == nbits - 4'd1) begin
                                state <= cfg_par_en ? RX_PAR : RX_STOP;
                            end else begin
                                bitn <= bitn + 1'b1;
                            end
                        end
                    end
                    RX_PAR: begin
                        cnt <= cnt + 1'b1;
                        if (centre) begin
                            cnt     <= '0;
                            par_bit <= sync_b;
                            all_low <= all_low & ~sync_b;
                            state   <= RX_STOP;
                        end
                    end
                    RX_STOP: begin
                        cnt <= cnt + 1'b1;
                        if (centre) begin
                            cnt        <= '0;
                            char_valid <= 1'b1;
                            if (all_low && !sync_b) begin
                                char_out <= '{brk: 1'b1, frm: 1'b0, par: 1'b0, data: 8'h00};
                                state    <= RX_HOLD;
                            end else begin
                                char_out.brk  <= 1'b0;
                                char_out.frm  <= ~sync_b;
                                char_out.par  <= cfg_par_en & (par_bit != (ones_par ^ ~cfg_par_even));
                                char_out.data <= shreg >> (4'd8 - nbits);
                                state         <= RX_IDLE;
                            end
                        end
                    end
                    RX_HOLD: begin
                        if (sync_b) state <= RX_IDLE;
                    end
                    default: state <= RX_IDLE;
                endcase
            end
        end
    end

    // R6: while waiting for the line to rise after a break, nothing is loaded
    a_r6_no_char_during_hold: assert property (@(posedge clk) disable iff (rst)
        (state == RX_HOLD && $past(state) == RX_HOLD) |-> !char_valid);

    // R5: after every completed character the receiver is hunting or holding
    a_r5_resync_after_char: assert property (@(posedge clk) disable iff (rst)
        char_valid |-> (state == RX_IDLE || state == RX_HOLD));

    // R6: a break character always carries zero data and no other flag
    a_r6_break_clean: assert property (@(posedge clk) disable iff (rst)
        (char_valid && char_out.brk) |-> (char_out.data == 8'h00 && !char_out.frm && !char_out.par));

endmodule

// File: rtl/uart_rx_queue.sv
module uart_rx_queue
    import uart_rx_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     clr,
    input  logic     push,
    input  rx_char_t push_char,
    input  logic     pop,
    output rx_char_t head,
    output logic     empty,
    output logic     full,
    output logic [$clog2(DEPTH):0] count
);
    localparam int AW = $clog2(DEPTH);

    rx_char_t      mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic          push_ok, pop_ok;

    assign empty   = (count == '0);
    assign full    = (count == (AW+1)'(DEPTH));
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign head    = empty ? '0 : mem[rptr];

    always_ff @(posedge clk) begin
        if (push_ok && !clr && !rst) mem[wptr] <= push_char;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push_ok) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
            if (pop_ok)  rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R7: the level never exceeds the queue depth
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (rst)
        count <= (AW+1)'(DEPTH));

    // R7: a pop on an empty queue leaves it empty
    a_r7_empty_pop: assert property (@(posedge clk) disable iff (rst)
        (empty && pop && !push) |=> empty);

    // R8: a push into a full queue with no pop leaves the level unchanged
    a_r8_full_keeps_level: assert property (@(posedge clk) disable iff (rst)
        (full && push && !pop && !clr) |=> $stable(count));

endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
    import uart_rx_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     clr,
    input  logic     push,
    input  rx_char_t push_char,
    input  logic     pop,
    input  rx_char_t head,
    input  logic     empty,
    input  logic     full,
    input  logic [$clog2(DEPTH):0] count,
    input  logic     ovr_ack,
    input  logic [1:0] cfg_trig,
    output logic     st_overrun,
    output logic     st_q_err,
    output logic     trig_hit
);
    localparam int CNTW = $clog2(DEPTH) + 1;

    logic [CNTW-1:0] err_cnt;
    logic            err_in, err_out;

    assign err_in  = push && !full && has_err(push_char);
    assign err_out = pop && !empty && has_err(head);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            err_cnt <= '0;
        end else begin
            case ({err_in, err_out})
                2'b10:   err_cnt <= err_cnt + 1'b1;
                2'b01:   err_cnt <= err_cnt - 1'b1;
                default: err_cnt <= err_cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_overrun <= 1'b0;
        end else if (push && full) begin
            st_overrun <= 1'b1;
        end else if (ovr_ack) begin
            st_overrun <= 1'b0;
        end
    end

    assign st_q_err = (err_cnt != '0);
    assign trig_hit = (32'(count) >= trig_level(cfg_trig));

    // R11: an empty queue can hold no erroneous character
    a_r11_empty_no_err: assert property (@(posedge clk) disable iff (rst)
        empty |-> !st_q_err);

    // R10: the trigger never fires with nothing queued
    a_r10_trig_needs_data: assert property (@(posedge clk) disable iff (rst)
        trig_hit |-> !empty);

    // R8: overrun rises only when a character met a full queue
    a_r8_overrun_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(st_overrun) |-> $past(push && full));

endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
    import uart_rx_pkg::*;
#(
    parameter int OSR   = 16,
    parameter int DEPTH = 64,
    localparam int LW   = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          baud_tick,
    input  logic          rx_line,
    input  logic [1:0]    cfg_wlen,
    input  logic          cfg_two_stop,
    input  logic          cfg_par_en,
    input  logic          cfg_par_even,
    input  logic [1:0]    cfg_trig,
    input  logic          q_clear,
    input  logic          q_pop,
    input  logic          ovr_ack,
    output logic [7:0]    rd_data,
    output logic          st_ready,
    output logic          st_overrun,
    output logic          st_parity,
    output logic          st_framing,
    output logic          st_break,
    output logic          st_q_err,
    output logic          trig_hit,
    output logic [LW-1:0] fill_level
);
    rx_char_t new_char, head;
    logic     new_valid, q_empty, q_full;
    logic     unused_two_stop;

    // only the first stop bit is ever checked
    assign unused_two_stop = cfg_two_stop;

    uart_rx_frame #(.OSR(OSR)) u_frame (
        .clk          (clk),
        .rst          (rst),
        .baud_tick    (baud_tick),
        .rx_line      (rx_line),
        .cfg_wlen     (cfg_wlen),
        .cfg_par_en   (cfg_par_en),
        .cfg_par_even (cfg_par_even),
        .char_valid   (new_valid),
        .char_out     (new_char)
    );

    uart_rx_queue #(.DEPTH(DEPTH)) u_queue (
        .clk       (clk),
        .rst       (rst),
        .clr       (q_clear),
        .push      (new_valid),
        .push_char (new_char),
        .pop       (q_pop),
        .head      (head),
        .empty     (q_empty),
        .full      (q_full),
        .count     (fill_level)
    );

    uart_rx_status #(.DEPTH(DEPTH)) u_status (
        .clk        (clk),
        .rst        (rst),
        .clr        (q_clear),
        .push       (new_valid),
        .push_char  (new_char),
        .pop        (q_pop),
        .head       (head),
        .empty      (q_empty),
        .full       (q_full),
        .count      (fill_level),
        .ovr_ack    (ovr_ack),
        .cfg_trig   (cfg_trig),
        .st_overrun (st_overrun),
        .st_q_err   (st_q_err),
        .trig_hit   (trig_hit)
    );

    assign rd_data    = head.data;
    assign st_ready   = !q_empty;
    assign st_parity  = head.par;
    assign st_framing = head.frm;
    assign st_break   = head.brk;

    // R12: head flags are quiet when nothing is queued
    a_r12_flags_need_data: assert property (@(posedge clk) disable iff (rst)
        !st_ready |-> !(st_parity || st_framing || st_break));

    // R9: a clear leaves the queue empty on the next cycle
    a_r9_clear_empties: assert property (@(posedge clk) disable iff (rst)
        q_clear |=> (fill_level == '0));

endmodule

// File: tb/uart_rx_core_bench.sv
module uart_rx_core_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_line = 1'b1;
    logic [1:0] cfg_wlen = 2'b11;
    logic       cfg_two_stop = 1'b0;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_even = 1'b0;
    logic [1:0] cfg_trig = 2'b00;
    logic       q_clear = 1'b0;
    logic       q_pop = 1'b0;
    logic       ovr_ack = 1'b0;
    logic [7:0] rd_data;
    logic       st_ready, st_overrun, st_parity, st_framing, st_break, st_q_err, trig_hit;
    logic [6:0] fill_level;

    int checks = 0;
    int errors = 0;
    logic [10:0] model_q[$];
    logic        model_ovr = 1'b0;

    always #4 clk = ~clk;

    uart_rx_core u_uart_rx_core (
        .clk(clk), .rst(rst), .baud_tick(1'b1), .rx_line(rx_line),
        .cfg_wlen(cfg_wlen), .cfg_two_stop(cfg_two_stop), .cfg_par_en(cfg_par_en),
        .cfg_par_even(cfg_par_even), .cfg_trig(cfg_trig), .q_clear(q_clear),
        .q_pop(q_pop), .ovr_ack(ovr_ack), .rd_data(rd_data), .st_ready(st_ready),
        .st_overrun(st_overrun), .st_parity(st_parity), .st_framing(st_framing),
        .st_break(st_break), .st_q_err(st_q_err), .trig_hit(trig_hit),
        .fill_level(fill_level)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_trig(input logic [1:0] code, input int lvl);
        int th;
        th = (code == 2'd0) ? 1 : (code == 2'd1) ? 16 : (code == 2'd2) ? 32 : 56;
        return (lvl >= th) ? 1 : 0;
    endfunction

    function automatic int exp_qerr();
        foreach (model_q[i]) if (model_q[i][10:8] != 3'b000) return 1;
        return 0;
    endfunction

    task automatic bit_time(input logic v, input int n);
        rx_line = v;
        repeat (n) @(negedge clk);
    endtask

    // send one frame with current config; bad_stop drives a low stop bit
    task automatic send(input logic [7:0] d, input logic flip_par, input logic bad_stop);
        int nb;
        logic [7:0] dm;
        logic pb, pe;
        nb = 5 + int'(cfg_wlen);
        dm = d & ((8'd1 << nb) - 8'd1);
        pb = (^dm) ^ ~cfg_par_even ^ flip_par;
        bit_time(1'b0, 16);
        for (int i = 0; i < nb; i++) bit_time(dm[i], 16);
        if (cfg_par_en) bit_time(pb, 16);
        if (bad_stop) begin
            bit_time(1'b0, 12);
            bit_time(1'b1, 12);
        end else begin
            bit_time(1'b1, cfg_two_stop ? 32 : 16);
        end
        bit_time(1'b1, 8);
        pe = cfg_par_en & flip_par;
        if (model_q.size() == 64) model_ovr = 1'b1;
        else model_q.push_back({1'b0, bad_stop, pe, dm});
    endtask

    task automatic send_break();
        int nb;
        nb = 5 + int'(cfg_wlen) + (cfg_par_en ? 1 : 0) + 2;
        bit_time(1'b0, nb * 16 + 48);
        bit_time(1'b1, 24);
        if (model_q.size() == 64) model_ovr = 1'b1;
        else model_q.push_back({3'b100, 8'h00});
    endtask

    task automatic check_status(input string tag);
        check({tag, " R7 fill"}, int'(fill_level), model_q.size());
        check({tag, " R7 ready"}, int'(st_ready), (model_q.size() != 0) ? 1 : 0);
        check({tag, " R11 qerr"}, int'(st_q_err), exp_qerr());
        check({tag, " R8 ovr"}, int'(st_overrun), int'(model_ovr));
        check({tag, " R10 trig"}, int'(trig_hit), exp_trig(cfg_trig, model_q.size()));
    endtask

    task automatic pop_check(input string tag);
        logic [10:0] e;
        if (model_q.size() == 0) begin
            e = 11'd0;
        end else begin
            e = model_q.pop_front();
        end
        check({tag, " R3 data"}, int'(rd_data), int'(e[7:0]));
        check({tag, " R4/R12 par"}, int'(st_parity), int'(e[8]));
        check({tag, " R5/R12 frm"}, int'(st_framing), int'(e[9]));
        check({tag, " R6/R12 brk"}, int'(st_break), int'(e[10]));
        q_pop = 1'b1;
        @(negedge clk);
        q_pop = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);

        // R1: reset state
        check("R1 fill", int'(fill_level), 0);
        check("R1 flags", int'({st_ready, st_overrun, st_parity, st_framing, st_break, st_q_err, trig_hit}), 0);

        // R2: short glitch loads nothing
        bit_time(1'b0, 5);
        bit_time(1'b1, 40);
        check("R2 glitch ignored", int'(fill_level), 0);

        // R3: each word length, directed pattern
        for (int w = 0; w < 4; w++) begin
            cfg_wlen = 2'(w);
            send(8'hD5, 1'b0, 1'b0);
            check_status("R3 wlen");
            pop_check("R3 wlen");
        end

        // R4: even and odd parity, good and corrupted
        cfg_wlen = 2'b11;
        cfg_par_en = 1'b1;
        for (int k = 0; k < 4; k++) begin
            cfg_par_even = k[0];
            send(8'h6B, k[1], 1'b0);
            check_status("R4 parity");
            pop_check("R4 parity");
        end

        // R5: framing error then clean recovery
        cfg_par_en = 1'b0;
        send(8'h3C, 1'b0, 1'b1);
        send(8'hA5, 1'b0, 1'b0);
        check_status("R5 resync");
        pop_check("R5 framing");
        pop_check("R5 after");

        // R6: break with parity enabled, then normal character
        cfg_par_en = 1'b1;
        cfg_par_even = 1'b1;
        send_break();
        check_status("R6 break");
        send(8'h81, 1'b0, 1'b0);
        check("R6 single break char", int'(fill_level), model_q.size());
        pop_check("R6 break");
        check_status("R6 after pop");
        pop_check("R6 next");

        // R7: pop when empty has no effect
        q_pop = 1'b1;
        @(negedge clk);
        q_pop = 1'b0;
        check("R7 empty pop", int'(fill_level), 0);
        check("R7 empty pop ready", int'(st_ready), 0);

        // R10/R8: fill to 64, sweeping trigger codes at each level
        cfg_par_en = 1'b0;
        cfg_wlen = 2'b11;
        for (int n = 0; n < 64; n++) begin
            send(8'(n * 7 + 3), 1'b0, (n == 10) ? 1'b1 : 1'b0);
            for (int c = 0; c < 4; c++) begin
                cfg_trig = 2'(c);
                #1;
                check("R10 trigger", int'(trig_hit), exp_trig(2'(c), model_q.size()));
            end
        end
        check_status("R8 full");
        send(8'hEE, 1'b0, 1'b0);
        check_status("R8 overrun");
        pop_check("R8 head kept");
        ovr_ack = 1'b1;
        @(negedge clk);
        ovr_ack = 1'b0;
        model_ovr = 1'b0;
        check_status("R8 ack");

        // R9: clear empties queue, overrun untouched
        for (int i = 0; i < 2; i++) send(8'h11, 1'b0, 1'b0);
        check("R9 pre-clear overrun", int'(st_overrun), 1);
        model_ovr = 1'b1;
        q_clear = 1'b1;
        @(negedge clk);
        q_clear = 1'b0;
        model_q.delete();
        check_status("R9 clear");
        ovr_ack = 1'b1;
        @(negedge clk);
        ovr_ack = 1'b0;
        model_ovr = 1'b0;

        // random frames
        for (int r = 0; r < 40; r++) begin
            logic [7:0] d;
            logic bad, flip;
            cfg_wlen = 2'($urandom_range(3));
            cfg_par_en = 1'($urandom_range(1));
            cfg_par_even = 1'($urandom_range(1));
            cfg_two_stop = 1'($urandom_range(1));
            cfg_trig = 2'($urandom_range(3));
            d = 8'($urandom_range(255));
            bad = ($urandom_range(4) == 0);
            flip = ($urandom_range(3) == 0);
            if (bad) d = d | 8'h01;
            send(d, flip, bad);
            check_status("rand R4/R5");
            if ($urandom_range(2) == 0) pop_check("rand R3");
        end
        while (model_q.size() != 0) begin
            pop_check("drain R3");
            check_status("drain R11");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule